// File: doc/BRIEF.md
# Programmable CRT Timing Generator

This block produces raster timing for a cathode-ray or flat display from a small set of byte-wide registers. Software selects a register with an index and writes a byte. The generator then runs a horizontal counter in character clocks, where one character equals eight pixels and one design clock equals one character clock. It also runs a vertical counter in scan lines. From these two counters it derives horizontal and vertical sync, a combined blanking signal and a display-enable window. It also presents the live character and line counts, so that downstream fetch logic can address pixels.

The vertical values are 11 bits wide. Each is split into a low byte, bits 8 and 9 in a shared overflow byte, and bit 10 in an extension byte. Some values are stored with a bias. Sync and blank ends are stored only as low-order bits and are detected when those bits match. A separate output-control byte sets the sync polarities. A protect bit freezes the low group of horizontal registers. Double scan repeats every line. An interlace flag runs alternate fields.

Top module: `crtc_timing_gen`

## Requirements
- R1: The character count runs from 0 up to the value at index 0x00 (total characters minus one) and then returns to 0. It advances once per clock.
- R2: The vertical total is stored as line count minus 2. Its low byte is at index 0x06, bit 8 at 0x07 bit 0, bit 9 at 0x07 bit 5 and bit 10 at 0x30 bit 3. The line count advances at the end of each line and wraps to 0 after reaching the stored value plus one.
- R3: The stored display end is the last visible position. It is horizontal at index 0x01 and vertical at index 0x12, with bit 8 at 0x07 bit 1, bit 9 at 0x07 bit 6 and bit 10 at 0x30 bit 2. disp_en is high only while the character count is at or below the horizontal value and the line count is at or below the vertical value.
- R4: Horizontal sync goes active at the character count held in index 0x04. It goes inactive at the first later count whose low 5 bits equal index 0x05 bits 4:0. When the two are equal, the pulse lasts 32 characters.
- R5: Horizontal blank starts at the count in index 0x02. It ends at the first later count whose low 6 bits equal the end value. That end value takes bits 4:0 from index 0x03 and bit 5 from index 0x05 bit 7.
- R6: Vertical sync starts at the line held in index 0x10, with bit 8 at 0x07 bit 2, bit 9 at 0x07 bit 7 and bit 10 at 0x30 bit 0. It ends at the first later line whose low 4 bits equal index 0x11 bits 3:0.
- R7: Vertical blank starts one line after the stored start value. The low byte of that value is at index 0x15, bit 8 at 0x07 bit 3, bit 9 at 0x09 bit 5 and bit 10 at 0x30 bit 1. Vertical blank ends at the first later line whose low 8 bits equal index 0x16. The blank output is high whenever horizontal or vertical blank is active.
- R8: Bits 6 and 7 of the output-control byte, written through misc_wr, invert horizontal and vertical sync respectively, so that a set bit gives an active-low pulse.
- R9: With index 0x09 bit 7 set, each line count value is held for two line periods.
- R10: With index 0x30 bit 7 set, the field output toggles at every vertical wrap. The display-end line is compared after halving, while all other vertical values are used as written. With the bit clear, field returns to 0 at the next wrap.
- R11: While index 0x11 bit 7 is set, writes to indices 0x00 through 0x07 are ignored. All other indices, including 0x11 itself, stay writable.
- R12: After reset, all registers and both counters are zero. The outputs then show counts 0, disp_en high, blank, both syncs and field low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the indexed register file |
| reg_idx | input | IDX_W | Register index |
| reg_wdata | input | 8 | Register write data |
| misc_wr | input | 1 | Write strobe for the output-control byte |
| misc_wdata | input | 8 | Output-control data (bit 6 horizontal, bit 7 vertical polarity) |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| blank | output | 1 | Horizontal or vertical blank |
| disp_en | output | 1 | Active display window |
| field | output | 1 | Interlace field indicator |
| char_cnt | output | HW | Character count within the line |
| line_cnt | output | VW | Line count within the frame or field |

## Verification
The edge most likely to hide a fault is the end of a line. There a register write, the horizontal wrap, the vertical step with its sync, blank and field updates, and the double-scan hold can all take effect in the same clock. A short horizontal total of four characters makes line ends frequent, and the bench writes the overflow, scan and extension bytes while the counters run, so that many writes fall on a wrap. A per-cycle reference model applies each write only after the old settings have stepped the counters. Every cycle's count, sync, blank, enable and field values are compared against it, so a write taking effect one cycle early or late shows up as a mismatch.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

   localparam int BYTE_W  = 8;
   localparam int VFLD_W  = 11;
   localparam int HSE_W   = 5;
   localparam int HBE_W   = 6;
   localparam int VSE_W   = 4;
   localparam int VBE_W   = 8;

   // storage slots; slots 0..7 sit at indices 0x00..0x07 (the guarded group)
   localparam int S_HTOT = 0;
   localparam int S_HDE  = 1;
   localparam int S_HBS  = 2;
   localparam int S_HBE  = 3;
   localparam int S_HSS  = 4;
   localparam int S_HSE  = 5;
   localparam int S_VTOT = 6;
   localparam int S_OVF  = 7;
   localparam int S_SCAN = 8;
   localparam int S_VSS  = 9;
   localparam int S_VSE  = 10;
   localparam int S_VDE  = 11;
   localparam int S_VBS  = 12;
   localparam int S_VBE  = 13;
   localparam int S_EXT  = 14;
   localparam int NSLOT  = 15;

   localparam int GUARD_LAST = 7;
   localparam int GUARD_BIT  = 7;

   function automatic logic [7:0] slot_index(int s);
      case (s)
         S_SCAN:  return 8'h09;
         S_VSS:   return 8'h10;
         S_VSE:   return 8'h11;
         S_VDE:   return 8'h12;
         S_VBS:   return 8'h15;
         S_VBE:   return 8'h16;
         S_EXT:   return 8'h30;
         default: return 8'(s);
      endcase
   endfunction

   typedef struct packed {
      logic [7:0]        htot;
      logic [7:0]        hde;
      logic [7:0]        hbs;
      logic [HBE_W-1:0]  hbe;
      logic [7:0]        hss;
      logic [HSE_W-1:0]  hse;
      logic [VFLD_W-1:0] vtot;
      logic [VFLD_W-1:0] vde;
      logic [VFLD_W-1:0] vss;
      logic [VFLD_W-1:0] vbs;
      logic [VSE_W-1:0]  vse;
      logic [VBE_W-1:0]  vbe;
      logic              dbl;
      logic              ilace;
      logic              hneg;
      logic              vneg;
   } crtc_cfg_t;

endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
   import crtc_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       wdata,
   input  logic             misc_wr,
   input  logic [7:0]       misc_wdata,
   output crtc_cfg_t        cfg
);

   logic [NSLOT-1:0][7:0] slot_q;
   logic [1:0]            pol_q;
   logic                  guard;

   assign guard = slot_q[S_VSE][GUARD_BIT];

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam logic [7:0] IX      = slot_index(s);
      localparam bit         GUARDED = (s <= GUARD_LAST);
      logic       hit;
      logic [7:0] q;
      assign hit = wr && (idx == IDX_W'(IX)) && !(GUARDED && guard);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (hit) q <= wdata;
      end
      assign slot_q[s] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pol_q <= '0;
      else if (misc_wr) pol_q <= misc_wdata[7:6];
   end

   always_comb begin
      cfg.htot  = slot_q[S_HTOT];
      cfg.hde   = slot_q[S_HDE];
      cfg.hbs   = slot_q[S_HBS];
      cfg.hbe   = {slot_q[S_HSE][7], slot_q[S_HBE][4:0]};
      cfg.hss   = slot_q[S_HSS];
      cfg.hse   = slot_q[S_HSE][4:0];
      cfg.vtot  = {slot_q[S_EXT][3], slot_q[S_OVF][5], slot_q[S_OVF][0], slot_q[S_VTOT]};
      cfg.vde   = {slot_q[S_EXT][2], slot_q[S_OVF][6], slot_q[S_OVF][1], slot_q[S_VDE]};
      cfg.vss   = {slot_q[S_EXT][0], slot_q[S_OVF][7], slot_q[S_OVF][2], slot_q[S_VSS]};
      cfg.vbs   = {slot_q[S_EXT][1], slot_q[S_SCAN][5], slot_q[S_OVF][3], slot_q[S_VBS]};
      cfg.vse   = slot_q[S_VSE][3:0];
      cfg.vbe   = slot_q[S_VBE];
      cfg.dbl   = slot_q[S_SCAN][7];
      cfg.ilace = slot_q[S_EXT][7];
      cfg.hneg  = pol_q[0];
      cfg.vneg  = pol_q[1];
   end

   logic unused_bits;
   assign unused_bits = ^{slot_q[S_HBE][7:5], slot_q[S_HSE][6:5], slot_q[S_OVF][4],
                          slot_q[S_SCAN][6], slot_q[S_SCAN][4:0], slot_q[S_VSE][6:4],
                          slot_q[S_EXT][6:4], misc_wdata[5:0]};

   // R11: guarded group holds its contents while the guard bit is set
   a_r11_guarded_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && guard && (idx <= IDX_W'(GUARD_LAST))) |=> $stable(slot_q[GUARD_LAST:0]));

endmodule

// File: rtl/crtc_hcnt.sv
module crtc_hcnt
   import crtc_pkg::*;
#(
   parameter int HW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       htot,
   input  logic [7:0]       hbs,
   input  logic [HBE_W-1:0] hbe,
   input  logic [7:0]       hss,
   input  logic [HSE_W-1:0] hse,
   output logic [HW-1:0]    h,
   output logic             line_end,
   output logic             hs,
   output logic             hb
);

   logic [HW-1:0] h_nx;
   logic          hs_nx, hb_nx;

   assign line_end = (h == HW'(htot));
   assign h_nx     = line_end ? '0 : h + HW'(1);

   always_comb begin
      if (h_nx == HW'(hss))             hs_nx = 1'b1;
      else if (h_nx[HSE_W-1:0] == hse)  hs_nx = 1'b0;
      else                              hs_nx = hs;
      if (h_nx == HW'(hbs))             hb_nx = 1'b1;
      else if (h_nx[HBE_W-1:0] == hbe)  hb_nx = 1'b0;
      else                              hb_nx = hb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h  <= '0;
         hs <= 1'b0;
         hb <= 1'b0;
      end else begin
         h  <= h_nx;
         hs <= hs_nx;
         hb <= hb_nx;
      end
   end

   a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      line_end |=> (h == '0));
   a_r4_sync_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs) |-> (h == HW'($past(hss))));
   a_r4_sync_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs) |-> (h[HSE_W-1:0] == $past(hse)));
   a_r5_blank_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hb) |-> (h[HBE_W-1:0] == $past(hbe)));

endmodule

// File: rtl/crtc_vcnt.sv
module crtc_vcnt
   import crtc_pkg::*;
#(
   parameter int VW = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_end,
   input  logic [VFLD_W-1:0] vtot,
   input  logic [VFLD_W-1:0] vss,
   input  logic [VSE_W-1:0]  vse,
   input  logic [VFLD_W-1:0] vbs,
   input  logic [VBE_W-1:0]  vbe,
   input  logic              dbl,
   input  logic              ilace,
   output logic [VW-1:0]     v,
   output logic              vs,
   output logic              vb,
   output logic              field
);

   localparam int XW = VW + 1;

   logic          rep_q;
   logic          adv, wrap;
   logic [VW-1:0] v_nx;
   logic [XW-1:0] last_line, blank_line;

   assign adv        = line_end && !(dbl && !rep_q);
   assign last_line  = XW'(vtot) + XW'(1);
   assign blank_line = XW'(vbs) + XW'(1);
   assign wrap       = ({1'b0, v} == last_line);
   assign v_nx       = wrap ? '0 : v + VW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rep_q <= 1'b0;
         v     <= '0;
         vs    <= 1'b0;
         vb    <= 1'b0;
         field <= 1'b0;
      end else begin
         if (line_end) rep_q <= dbl && !rep_q;
         if (adv) begin
            v <= v_nx;
            if (v_nx == VW'(vss))                  vs <= 1'b1;
            else if (v_nx[VSE_W-1:0] == vse)       vs <= 1'b0;
            if ({1'b0, v_nx} == blank_line)        vb <= 1'b1;
            else if (v_nx[VBE_W-1:0] == vbe)       vb <= 1'b0;
            if (wrap) field <= ilace && !field;
         end
      end
   end

   a_r2_hold_mid_line: assert property (@(posedge clk) disable iff (!rst_n)
      !line_end |=> $stable(v));
   a_r9_repeat_line: assert property (@(posedge clk) disable iff (!rst_n)
      (line_end && dbl && !rep_q) |=> $stable(v));
   a_r6_vsync_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vs) |-> (v[VSE_W-1:0] == $past(vse)));
   a_r7_vblank_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vb) |-> ({1'b0, v} == (XW'($past(vbs)) + XW'(1))));
   a_r10_field_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(field) |-> (v == '0));

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
   import crtc_pkg::*;
#(
   parameter int HW    = 8,
   parameter int VW    = 11,
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [IDX_W-1:0] reg_idx,
   input  logic [7:0]       reg_wdata,
   input  logic             misc_wr,
   input  logic [7:0]       misc_wdata,
   output logic             hsync,
   output logic             vsync,
   output logic             blank,
   output logic             disp_en,
   output logic             field,
   output logic [HW-1:0]    char_cnt,
   output logic [VW-1:0]    line_cnt
);

   if (HW < BYTE_W) begin : g_bad_hw
      $error("HW must hold an 8-bit character total");
   end
   if (VW < VFLD_W) begin : g_bad_vw
      $error("VW must hold an 11-bit line value");
   end
   if (IDX_W < 6) begin : g_bad_idx
      $error("IDX_W must reach index 0x30");
   end

   crtc_cfg_t     cfg;
   logic          line_end, hs_raw, hb_raw, vs_raw, vb_raw;
   logic [VW-1:0] vde_full, vde_eff;

   crtc_regs #(.IDX_W(IDX_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
      .misc_wr(misc_wr), .misc_wdata(misc_wdata), .cfg(cfg)
   );

   crtc_hcnt #(.HW(HW)) i_hcnt (
      .clk(clk), .rst_n(rst_n), .htot(cfg.htot), .hbs(cfg.hbs), .hbe(cfg.hbe),
      .hss(cfg.hss), .hse(cfg.hse), .h(char_cnt), .line_end(line_end),
      .hs(hs_raw), .hb(hb_raw)
   );

   crtc_vcnt #(.VW(VW)) i_vcnt (
      .clk(clk), .rst_n(rst_n), .line_end(line_end), .vtot(cfg.vtot), .vss(cfg.vss),
      .vse(cfg.vse), .vbs(cfg.vbs), .vbe(cfg.vbe), .dbl(cfg.dbl), .ilace(cfg.ilace),
      .v(line_cnt), .vs(vs_raw), .vb(vb_raw), .field(field)
   );

   assign vde_full = VW'(cfg.vde);
   assign vde_eff  = cfg.ilace ? (vde_full >> 1) : vde_full;

   assign disp_en = (char_cnt <= HW'(cfg.hde)) && (line_cnt <= vde_eff);
   assign blank   = hb_raw | vb_raw;
   assign hsync   = hs_raw ^ cfg.hneg;
   assign vsync   = vs_raw ^ cfg.vneg;

   // R8: with no inversion, the sync pins follow the raw pulses
   a_r8_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.hneg && !cfg.vneg) |-> (hsync == hs_raw && vsync == vs_raw));

endmodule

// File: tb/test_crtc_timing_gen.sv
`timescale 1ns/1ps
module test_crtc_timing_gen;

   localparam int HW = 8, VW = 11, IDX_W = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic             reg_wr = 1'b0;
   logic [IDX_W-1:0] reg_idx = '0;
   logic [7:0]       reg_wdata = '0;
   logic             misc_wr = 1'b0;
   logic [7:0]       misc_wdata = '0;
   logic             hsync, vsync, blank, disp_en, field;
   logic [HW-1:0]    char_cnt;
   logic [VW-1:0]    line_cnt;

   crtc_timing_gen #(.HW(HW), .VW(VW), .IDX_W(IDX_W)) i_crtc_timing_gen (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .misc_wr(misc_wr), .misc_wdata(misc_wdata), .hsync(hsync), .vsync(vsync),
      .blank(blank), .disp_en(disp_en), .field(field), .char_cnt(char_cnt), .line_cnt(line_cnt)
   );

   typedef struct {
      string req;
      int    h, v;
      bit    hs, vs, bl, de, fld;
   } exp_t;

   exp_t  sb[$];
   int    checks = 0, fails = 0;
   string cur_req = "R12";

   // reference state
   int mr[256];
   int m_h = 0, m_v = 0;
   bit m_rep = 0, m_fld = 0, m_hs = 0, m_hb = 0, m_vs = 0, m_vb = 0, m_hneg = 0, m_vneg = 0;
   int c_htot, c_hde, c_hbs, c_hbe, c_hss, c_hse, c_vt, c_vde, c_vss, c_vbs, c_vse, c_vbe;
   bit c_dbl, c_il, c_guard;

   function automatic int bt(int val, int pos);
      return (val >> pos) & 1;
   endfunction

   task automatic load_cfg();
      c_htot = mr[8'h00]; c_hde = mr[8'h01]; c_hbs = mr[8'h02]; c_hss = mr[8'h04];
      c_hbe  = (mr[8'h03] & 31) | (bt(mr[8'h05], 7) << 5);
      c_hse  = mr[8'h05] & 31;
      c_vt   = mr[8'h06] | bt(mr[8'h07],0) << 8 | bt(mr[8'h07],5) << 9 | bt(mr[8'h30],3) << 10;
      c_vde  = mr[8'h12] | bt(mr[8'h07],1) << 8 | bt(mr[8'h07],6) << 9 | bt(mr[8'h30],2) << 10;
      c_vss  = mr[8'h10] | bt(mr[8'h07],2) << 8 | bt(mr[8'h07],7) << 9 | bt(mr[8'h30],0) << 10;
      c_vbs  = mr[8'h15] | bt(mr[8'h07],3) << 8 | bt(mr[8'h09],5) << 9 | bt(mr[8'h30],1) << 10;
      c_vse  = mr[8'h11] & 15; c_vbe = mr[8'h16];
      c_dbl  = bt(mr[8'h09], 7); c_il = bt(mr[8'h30], 7); c_guard = bt(mr[8'h11], 7);
   endtask

   task automatic model_step(bit wr, int ix, int d, bit mw, int md);
      int  nh, nv;
      bit  le, wrap;
      exp_t e;
      load_cfg();
      le = (m_h == c_htot);
      nh = le ? 0 : (m_h + 1) % 256;
      if (nh == c_hss) m_hs = 1; else if ((nh % 32) == c_hse) m_hs = 0;
      if (nh == c_hbs) m_hb = 1; else if ((nh % 64) == c_hbe) m_hb = 0;
      if (le) begin
         if (c_dbl && !m_rep) m_rep = 1;
         else begin
            m_rep = 0;
            wrap = (m_v == c_vt + 1);
            nv = wrap ? 0 : (m_v + 1) % 2048;
            if (wrap) m_fld = c_il ? !m_fld : 1'b0;
            if (nv == c_vss) m_vs = 1; else if ((nv % 16) == c_vse) m_vs = 0;
            if (nv == c_vbs + 1) m_vb = 1; else if ((nv % 256) == c_vbe) m_vb = 0;
            m_v = nv;
         end
      end
      m_h = nh;
      if (wr && !(c_guard && ix <= 7)) mr[ix] = d;   // R11 guard uses the old bit
      if (mw) begin m_hneg = bt(md, 6); m_vneg = bt(md, 7); end
      load_cfg();
      e.req = cur_req; e.h = m_h; e.v = m_v;
      e.hs = m_hs ^ m_hneg; e.vs = m_vs ^ m_vneg; e.bl = m_hb | m_vb; e.fld = m_fld;
      e.de = (m_h <= c_hde) && (m_v <= (c_il ? (c_vde >> 1) : c_vde));
      sb.push_back(e);
   endtask

   task automatic cyc(bit wr, int ix, int d, bit mw, int md);
      reg_wr = wr; reg_idx = IDX_W'(ix); reg_wdata = 8'(d);
      misc_wr = mw; misc_wdata = 8'(md);
      @(posedge clk);
      model_step(wr, ix, d, mw, md);
      @(negedge clk);
      reg_wr = 1'b0; misc_wr = 1'b0;
   endtask

   task automatic wreg(int ix, int d);
      cyc(1'b1, ix, d, 1'b0, 0);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b0, 0);
   endtask

   // monitor: compare each expected item against the ports
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (int'(char_cnt) != e.h || int'(line_cnt) != e.v || hsync != e.hs ||
             vsync != e.vs || blank != e.bl || disp_en != e.de || field != e.fld) begin
            fails++;
            $display("FAIL %s: char %0d/%0d line %0d/%0d hsync %b/%b vsync %b/%b blank %b/%b de %b/%b field %b/%b (actual/expected)",
                     e.req, char_cnt, e.h, line_cnt, e.v, hsync, e.hs, vsync, e.vs,
                     blank, e.bl, disp_en, e.de, field, e.fld);
         end
      end
   end

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mr[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12: reset state at the ports
      checks++;
      if (char_cnt != 0 || line_cnt != 0 || !disp_en || blank || hsync || vsync || field) begin
         fails++;
         $display("FAIL R12: char %0d line %0d de %b blank %b hs %b vs %b field %b (expected 0 0 1 0 0 0 0)",
                  char_cnt, line_cnt, disp_en, blank, hsync, vsync, field);
      end
      cur_req = "R12"; idle(4);

      // R1 R3 R4 R5 R6 R7: small raster
      cur_req = "R1/R3/R4/R5/R6/R7";
      wreg(8'h00, 19); wreg(8'h01, 15); wreg(8'h02, 16); wreg(8'h03, 0);
      wreg(8'h04, 17); wreg(8'h05, 19); wreg(8'h06, 10); wreg(8'h07, 0);
      wreg(8'h12, 7);  wreg(8'h10, 9);  wreg(8'h11, 8'h0B);
      wreg(8'h15, 8);  wreg(8'h16, 0);
      idle(600);

      // R4 32-wide sync, R5 blank end bit 5 from index 0x05 bit 7
      cur_req = "R4/R5";
      wreg(8'h00, 47); wreg(8'h02, 40); wreg(8'h03, 8'h03);
      wreg(8'h04, 10); wreg(8'h05, 8'h8A);
      idle(1200);

      // R8: inverted syncs
      cur_req = "R8";
      cyc(1'b0, 0, 0, 1'b1, 8'hC0);
      idle(300);
      cyc(1'b0, 0, 0, 1'b1, 8'h40);
      idle(200);
      cyc(1'b0, 0, 0, 1'b1, 8'h00);

      // R2 R3 R6 R7: bit 8 of every vertical value from index 0x07
      cur_req = "R2/R6/R7";
      wreg(8'h00, 3); wreg(8'h06, 2); wreg(8'h12, 0); wreg(8'h10, 3); wreg(8'h15, 1);
      wreg(8'h07, 8'h0F);
      idle(1100);
      // R2: bit 10 from index 0x30
      cur_req = "R2";
      wreg(8'h07, 8'h00); wreg(8'h30, 8'h0F);
      idle(4200);
      // R7: blank start bit 9 from index 0x09 bit 5, total bit 9 from 0x07 bit 5
      cur_req = "R7";
      wreg(8'h30, 8'h00); wreg(8'h07, 8'h20); wreg(8'h09, 8'h20);
      idle(2100);

      // R9: double scan
      cur_req = "R9";
      wreg(8'h07, 0); wreg(8'h09, 8'h80); wreg(8'h00, 19); wreg(8'h06, 10);
      wreg(8'h12, 7); wreg(8'h10, 9); wreg(8'h15, 8);
      idle(1000);

      // R10: interlace field and halved display end
      cur_req = "R10";
      wreg(8'h09, 0); wreg(8'h30, 8'h80);
      idle(700);
      wreg(8'h30, 8'h00);
      idle(300);

      // R11: guarded writes ignored, others accepted
      cur_req = "R11";
      wreg(8'h11, 8'h8B);
      wreg(8'h00, 5); wreg(8'h07, 8'hFF); wreg(8'h01, 2);
      wreg(8'h12, 3);
      idle(300);
      wreg(8'h11, 8'h0B);
      wreg(8'h00, 5);
      idle(200);

      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

endmodule